// File: doc/BRIEF.md
# Timestamped Error Event Logger

This block sits behind one pattern-checker channel and keeps a record of everything worth knowing about the link. On every frame-clock cycle it sees the checker's mismatch word, the current lock flag and a link-reset pulse. A mismatch word with at least one bit set becomes an error record. A change of lock state or a reset pulse becomes a link record. Every record holds a 54-bit count of cycles since reset. Error records also hold the full 40-bit mismatch word. The transmitted and received data can therefore be rebuilt offline from the known test sequence.

Storage is split into two circular regions with their own pointers: a small one reserved for link records and a large one for error records. A burst of errors can fill the error region. New errors are then dropped and counted, while link records still go into their own space. A byte-wide valid/ready read port drains stored records toward a slow host link. Link records go out first, and each record leaves as twelve bytes.

Top module: `evt_logger`

## Requirements
- R1: Bits [93:40] of every record hold the number of clock cycles between the end of reset and the cycle in which the event was presented. The counter is 0 in the first cycle after reset.
- R2: An error record (bits [95:94] = 00, bits [39:0] = the mismatch word) is stored only in a cycle where `frame_valid` is high and `err_mask` is nonzero. At most one is stored per cycle.
- R3: An error record that finds the error region full is discarded, and `ovf_count` increments by one. The count saturates at 16'hFFFF.
- R4: A link record has bits [39:0] = 0. It is stored when `lock_in` differs from the last lock state recorded (type 01 = lock gained, 10 = lock lost), and when `link_reset_evt` is high (type 11). The recorded lock state is 0 after reset.
- R5: When a reset pulse and a lock change fall in the same cycle, the reset record is stored in that cycle. The lock record follows in the next cycle, if `lock_in` still differs then.
- R6: Link records are stored in their own region and are accepted whether or not the error region is full.
- R7: When the read side starts a new record, it takes a stored link record if one exists, and an error record only when the link region is empty. A record already being sent is never interrupted.
- R8: Each record leaves as 12 bytes, most significant byte (bits [95:88]) first. A byte stays on `rd_byte` with `rd_valid` high until a cycle with `rd_ready` high. The first byte appears two cycles after the record is taken.
- R9: After reset, `rd_valid` is low, `ovf_count` is 0 and both regions are empty.
- R10: Fullness is judged on the occupancy at the start of the cycle. A record read out in the same cycle does not make room for a write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Mismatch word valid this cycle |
| err_mask | input | PAT_W | Mismatch word (received XOR expected) |
| lock_in | input | 1 | Current lock state of the checker |
| link_reset_evt | input | 1 | One-cycle link reset indication |
| rd_valid | output | 1 | Byte available on rd_byte |
| rd_byte | output | 8 | Current byte of the record being read |
| rd_ready | input | 1 | Host accepts the byte this cycle |
| ovf_count | output | 16 | Saturating count of discarded error records |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write to the error region and a read that frees a slot in it. Full-speed error streams are run while the reader keeps draining, so reads regularly land on cycles where the region is full, and each such drop must show up in `ovf_count`. The second pair is a reset pulse and a lock change in one cycle. This is provoked directly, and the read-out order and timestamps of the two link records are compared against a queue-based reference model every clock. Separately, link events arrive while the error region is overflowing, to show they are kept and read out ahead of older errors.

// File: rtl/evt_log_pkg.sv
package evt_log_pkg;
  typedef enum logic [1:0] {
    KIND_ERR  = 2'b00,
    KIND_UP   = 2'b01,
    KIND_DOWN = 2'b10,
    KIND_RST  = 2'b11
  } rec_kind_e;

  typedef enum logic [1:0] {
    SER_IDLE = 2'b00,
    SER_LOAD = 2'b01,
    SER_SEND = 2'b10
  } ser_state_e;
endpackage

// File: rtl/evt_ring.sv
module evt_ring #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  // Storage and read register kept free of reset so block RAM fits.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_pop_no_room_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop) |=> (count == CW'(DEPTH - 1)));
endmodule

// File: rtl/evt_serial.sv
module evt_serial
  import evt_log_pkg::*;
#(
  parameter int REC_W = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_empty,
  input  logic             err_empty,
  input  logic [REC_W-1:0] link_data,
  input  logic [REC_W-1:0] err_data,
  output logic             link_pop,
  output logic             err_pop,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  input  logic             out_ready
);
  localparam int NB = REC_W / 8;
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  ser_state_e       state;
  logic             from_link;
  logic [REC_W-1:0] shreg;
  logic [IW-1:0]    idx;

  assign link_pop  = (state == SER_IDLE) && !link_empty;
  assign err_pop   = (state == SER_IDLE) && link_empty && !err_empty;
  assign out_valid = (state == SER_SEND);
  assign out_byte  = shreg[REC_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SER_IDLE;
      from_link <= 1'b0;
      shreg     <= '0;
      idx       <= '0;
    end else begin
      case (state)
        SER_IDLE: begin
          if (link_pop) begin
            from_link <= 1'b1;
            state     <= SER_LOAD;
          end else if (err_pop) begin
            from_link <= 1'b0;
            state     <= SER_LOAD;
          end
        end
        SER_LOAD: begin
          shreg <= from_link ? link_data : err_data;
          idx   <= '0;
          state <= SER_SEND;
        end
        SER_SEND: begin
          if (out_ready) begin
            if (idx == LAST_IDX) begin
              state <= SER_IDLE;
            end else begin
              shreg <= shreg << 8;
              idx   <= idx + 1'b1;
            end
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_frame_end_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && idx == LAST_IDX) |=> !out_valid);

  assert_pop_then_send_R8: assert property (@(posedge clk) disable iff (rst)
    (link_pop || err_pop) |=> !out_valid);
endmodule

// File: rtl/evt_logger.sv
module evt_logger
  import evt_log_pkg::*;
#(
  parameter int PAT_W      = 40,
  parameter int TS_W       = 54,
  parameter int ERR_DEPTH  = 3840,
  parameter int LINK_DEPTH = 256,
  parameter int OVF_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_valid,
  input  logic [PAT_W-1:0] err_mask,
  input  logic             lock_in,
  input  logic             link_reset_evt,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  input  logic             rd_ready,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int REC_W = 2 + TS_W + PAT_W;

  logic [TS_W-1:0]  ts;
  logic             seen_lock;
  logic             err_push, link_push, lock_diff;
  logic             err_full, link_full, err_empty, link_empty;
  logic             err_pop, link_pop;
  rec_kind_e        link_kind;
  logic [REC_W-1:0] err_word, link_word, err_rd, link_rd;

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  assign err_push = frame_valid && (|err_mask);
  assign err_word = {KIND_ERR, ts, err_mask};

  assign lock_diff = (lock_in != seen_lock);
  assign link_push = link_reset_evt || lock_diff;
  assign link_kind = link_reset_evt ? KIND_RST : (lock_in ? KIND_UP : KIND_DOWN);
  assign link_word = {link_kind, ts, {PAT_W{1'b0}}};

  // The recorded lock state moves only when its record is actually stored,
  // so a change blocked by a reset pulse or a full region is retried.
  always_ff @(posedge clk) begin
    if (rst) seen_lock <= 1'b0;
    else if (!link_reset_evt && lock_diff && !link_full) seen_lock <= lock_in;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_count <= '0;
    else if (err_push && err_full && (ovf_count != {OVF_W{1'b1}}))
      ovf_count <= ovf_count + 1'b1;
  end

  evt_ring #(.WIDTH(REC_W), .DEPTH(LINK_DEPTH)) link_ring_i (
    .clk(clk), .rst(rst), .push(link_push), .wdata(link_word),
    .pop(link_pop), .rdata(link_rd), .empty(link_empty), .full(link_full)
  );

  evt_ring #(.WIDTH(REC_W), .DEPTH(ERR_DEPTH)) err_ring_i (
    .clk(clk), .rst(rst), .push(err_push), .wdata(err_word),
    .pop(err_pop), .rdata(err_rd), .empty(err_empty), .full(err_full)
  );

  evt_serial #(.REC_W(REC_W)) serial_i (
    .clk(clk), .rst(rst),
    .link_empty(link_empty), .err_empty(err_empty),
    .link_data(link_rd), .err_data(err_rd),
    .link_pop(link_pop), .err_pop(err_pop),
    .out_valid(rd_valid), .out_byte(rd_byte), .out_ready(rd_ready)
  );

  assert_ts_step_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ts == $past(ts) + 1'b1));

  assert_ovf_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_count == $past(ovf_count)) || (ovf_count == $past(ovf_count) + 1'b1));

  assert_lock_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_lock != $past(seen_lock)) |-> ((seen_lock == $past(lock_in)) && !$past(link_reset_evt)));

  assert_link_first_R7: assert property (@(posedge clk) disable iff (rst)
    err_pop |-> !link_pop);
endmodule

// File: tb/evt_logger_tb.sv
module evt_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EDEP = 6;
  localparam int LDEP = 3;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst, frame_valid, lock_in, link_reset_evt, rd_ready;
  logic [39:0] err_mask;
  logic        rd_valid;
  logic [7:0]  rd_byte;
  logic [15:0] ovf_count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_logger #(.PAT_W(40), .TS_W(54), .ERR_DEPTH(EDEP), .LINK_DEPTH(LDEP), .OVF_W(16)) dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .err_mask(err_mask),
    .lock_in(lock_in), .link_reset_evt(link_reset_evt),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_ready(rd_ready), .ovf_count(ovf_count)
  );

  // Behavioural reference: two record queues and a byte-stream reader.
  logic [95:0] lq[$];
  logic [95:0] eq[$];
  logic [95:0] m_cur;
  logic [53:0] m_ts;
  logic [15:0] m_ovf;
  logic        m_lock;
  int          m_st;
  int          m_idx;

  always @(posedge clk) begin
    int nl;
    int ne;
    cyc++;
    if (rst) begin
      lq.delete(); eq.delete();
      m_ts = '0; m_ovf = '0; m_lock = 1'b0; m_st = 0; m_idx = 0; m_cur = '0;
    end else begin
      nl = lq.size();
      ne = eq.size();
      if (m_st == 0) begin
        if (nl > 0) begin m_cur = lq.pop_front(); m_st = 1; end
        else if (ne > 0) begin m_cur = eq.pop_front(); m_st = 1; end
      end else if (m_st == 1) begin
        m_st = 2; m_idx = 0;
      end else if (rd_ready) begin
        if (m_idx == 11) m_st = 0;
        else m_idx++;
      end
      if (frame_valid && err_mask != 40'd0) begin
        if (ne >= EDEP) begin
          if (m_ovf != 16'hFFFF) m_ovf++;
        end else eq.push_back({2'b00, m_ts, err_mask});
      end
      if (link_reset_evt) begin
        if (nl < LDEP) lq.push_back({2'b11, m_ts, 40'd0});
      end else if (lock_in != m_lock) begin
        if (nl < LDEP) begin
          lq.push_back({lock_in ? 2'b01 : 2'b10, m_ts, 40'd0});
          m_lock = lock_in;
        end
      end
      m_ts++;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Compare at every falling edge, away from the active edge.
  always @(negedge clk) begin
    logic [95:0] sh;
    if (!done) begin
      chk(cur_req, 64'(rd_valid), 64'(m_st == 2), "rd_valid");
      if (m_st == 2) begin
        sh = m_cur >> (8 * (11 - m_idx));
        chk(cur_req, 64'(rd_byte), 64'(sh[7:0]), "rd_byte");
      end
      chk(cur_req, 64'(ovf_count), 64'(m_ovf), "ovf_count");
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    while (cyc < WATCHDOG && !done) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst = 1; frame_valid = 0; err_mask = '0; lock_in = 0; link_reset_evt = 0; rd_ready = 0;
    step(3);
    cur_req = "R9";
    chk("R9", 64'(rd_valid), 64'd0, "rd_valid in reset");
    chk("R9", 64'(ovf_count), 64'd0, "ovf_count in reset");
    rst = 0;
    step(3);
    chk("R9", 64'(rd_valid), 64'd0, "rd_valid with empty regions");

    // R1 / R2: sparse error words, zero words and unqualified words
    cur_req = "R2";
    rd_ready = 1;
    for (int i = 0; i < 12; i++) begin
      frame_valid = (i % 3 != 2);
      err_mask = (i == 4) ? 40'd0 : {8'(i + 1), 32'hA5A5_0000 + 32'(i)};
      step(1);
    end
    frame_valid = 0; err_mask = '0;
    cur_req = "R1";
    step(120);

    // R4: lock gained, reset pulse, lock lost
    cur_req = "R4";
    lock_in = 1; step(20);
    link_reset_evt = 1; step(1); link_reset_evt = 0; step(20);
    lock_in = 0; step(20);

    // R5: reset pulse and lock change in one cycle
    cur_req = "R5";
    lock_in = 1; link_reset_evt = 1; step(1);
    link_reset_evt = 0; step(40);

    // R6 / R7: error overflow with link events arriving meanwhile
    cur_req = "R6";
    rd_ready = 0; step(2);
    for (int i = 0; i < 12; i++) begin
      frame_valid = 1;
      err_mask = {8'h3C, 32'(i * 7 + 1)};
      if (i == 5) lock_in = 0;
      step(1);
    end
    frame_valid = 0; err_mask = '0;
    lock_in = 1; step(1);
    cur_req = "R7";
    for (int i = 0; i < 250; i++) begin
      rd_ready = (i % 3 != 0);
      step(1);
    end
    cur_req = "R8";
    for (int i = 0; i < 60; i++) begin
      rd_ready = (i % 5 == 1);
      step(1);
    end
    rd_ready = 1; step(60);

    // R10: full-speed errors while the reader drains
    cur_req = "R10";
    for (int i = 0; i < 120; i++) begin
      frame_valid = 1;
      err_mask = {8'(i), 32'hF00D_0000 ^ 32'(i)};
      step(1);
    end
    frame_valid = 0; err_mask = '0;
    step(120);

    // R3: saturation of the drop counter
    cur_req = "R3";
    rd_ready = 0;
    frame_valid = 1; err_mask = 40'h01_0000_0001;
    step(65600);
    chk("R3", 64'(ovf_count), 64'hFFFF, "ovf_count saturated");
    frame_valid = 0; err_mask = '0;
    rd_ready = 1; step(150);
    chk("R3", 64'(ovf_count), 64'hFFFF, "ovf_count held");
    chk("R8", 64'(rd_valid), 64'd0, "drained");
    finish_run();
  end
endmodule